// File: doc/BRIEF.md
# Exclusive Access Monitor

This block sits beside a memory port and tracks one reservation for one execution thread. A load-exclusive request moves it into a reserved state and records the word address. A later store-exclusive to that same word may then complete. Any other outcome makes the conditional store fail. A failed store does not stall: the block holds back the write and returns a one-bit failure status, and software retries its read-modify-write loop.

The reservation is dropped in four cases: a successful or failed store-exclusive, an explicit clear pulse (interrupt or exception entry), and a plain store. Which plain stores drop it is set by a parameter: none, only those to the reserved word, or every plain store. The memory itself is outside the block. The block only drives the store-enable for the port, and the store-enable is combinational in the request cycle. The status and the alignment error come back one cycle later, together with a valid strobe.

Top module: `excl_monitor`

## Requirements
- R1: After reset the monitor is Open, `stat_valid` and `align_err` are 0, and a store-exclusive issued before any load-exclusive fails.
- R2: A word-aligned load-exclusive (op code 2) with no clear moves the monitor to Exclusive and records the word address (address bits above the byte offset).
- R3: A store-exclusive (op code 3) issued while Open drives `mem_we` low in its request cycle and returns status 1.
- R4: A store-exclusive to the reserved word while Exclusive drives `mem_we` high, returns status 0 and leaves the monitor Open, so a repeated store-exclusive fails.
- R5: A store-exclusive whose word address differs from the reserved word fails, with no write and status 1, and returns the monitor to Open.
- R6: Only one reservation exists: a second load-exclusive replaces the recorded address, so only a store-exclusive to the newer word can succeed.
- R7: A `mon_clear` pulse forces Open at the next edge. It takes priority over an exclusive request in the same cycle, and a store-exclusive issued with it fails without writing.
- R8: A plain store (op code 1) always drives `mem_we` high. With the default policy (STORE_POLICY=1) it drops the reservation only when its word address equals the reserved word.
- R9: An exclusive request with any nonzero byte-offset bit (WORD_BYTES=4: bits 1:0) raises `align_err` one cycle later, leaves the monitor state and recorded address unchanged, and never writes. A misaligned store-exclusive also reports status 1.
- R10: `stat_valid` is high for exactly the one cycle after each store-exclusive request and at no other time. `stat_fail` is meaningful only while it is high.
- R11: A plain load (op code 0) leaves the reservation untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 load, 1 store, 2 load-exclusive, 3 store-exclusive |
| req_addr | input | ADDR_W | Byte address of the request |
| mon_clear | input | 1 | Interrupt entry or explicit clear pulse |
| mem_we | output | 1 | Write enable to the memory port, same cycle as the request |
| stat_valid | output | 1 | Store-exclusive status strobe, one cycle after the request |
| stat_fail | output | 1 | 1 = conditional store failed, 0 = it completed |
| align_err | output | 1 | Misaligned exclusive request seen in the previous cycle |

## Verification
The bench crosses every aligned reserved word with every aligned store-exclusive word. A comparator that used too few or too many bits, or compared byte addresses, would let a mismatched store write or make a matching one fail. It sweeps plain stores over every word between a reservation and its store: a wrong policy would drop a reservation for an unrelated word or keep one after a hit on the reserved word. Clears that coincide with an exclusive request, misaligned exclusives whose state must survive, and back-to-back load-exclusives are each followed by a probing store-exclusive. A design that let the clear lose, or updated state on a misaligned request, would give the wrong status there.

// File: rtl/excl_pkg.sv
package excl_pkg;

  typedef enum logic [1:0] {
    OP_LD  = 2'd0,
    OP_ST  = 2'd1,
    OP_LDX = 2'd2,
    OP_STX = 2'd3
  } op_e;

  typedef enum logic {
    MON_OPEN = 1'b0,
    MON_EXCL = 1'b1
  } mon_e;

  // decoded request, qualified by valid
  typedef struct packed {
    logic ld;
    logic st;
    logic ldx;
    logic stx;
    logic misalign;
  } dec_t;

endpackage

// File: rtl/excl_decode.sv
module excl_decode
  import excl_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int WORD_BYTES = 4
) (
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  output dec_t              dec
);

  localparam int OFS_W = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 0;

  logic off_nz;

  generate
    if (OFS_W > 0) begin : g_ofs
      assign off_nz = |req_addr[OFS_W-1:0];
    end else begin : g_no_ofs
      assign off_nz = 1'b0;
    end
  endgenerate

  always_comb begin
    dec          = '0;
    dec.ld       = req_valid && (req_op == OP_LD);
    dec.st       = req_valid && (req_op == OP_ST);
    dec.ldx      = req_valid && (req_op == OP_LDX);
    dec.stx      = req_valid && (req_op == OP_STX);
    dec.misalign = off_nz;
  end

endmodule

// File: rtl/excl_resv.sv
module excl_resv
  import excl_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int WORD_BYTES   = 4,
  parameter int STORE_POLICY = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dec_t              dec,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              mon_clear,
  output mon_e              state,
  output logic              tag_hit
);

  localparam int OFS_W  = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 0;
  localparam int WORD_W = ADDR_W - OFS_W;

  logic [WORD_W-1:0] tag_q;
  logic [WORD_W-1:0] word_addr;
  logic              tag_en;
  logic              st_drop;
  mon_e              state_nx;

  assign word_addr = req_addr[ADDR_W-1:OFS_W];
  assign tag_hit   = (tag_q == word_addr);

  // plain-store policy: 0 never drops, 1 drops on reserved word, 2 drops always
  generate
    if (STORE_POLICY == 0) begin : g_pol_keep
      assign st_drop = 1'b0;
    end else if (STORE_POLICY == 1) begin : g_pol_match
      assign st_drop = dec.st && tag_hit;
    end else begin : g_pol_any
      assign st_drop = dec.st;
    end
  endgenerate

  always_comb begin
    state_nx = state;
    tag_en   = 1'b0;
    if (mon_clear) begin
      state_nx = MON_OPEN;
    end else if (dec.ldx && !dec.misalign) begin
      state_nx = MON_EXCL;
      tag_en   = 1'b1;
    end else if (dec.stx && !dec.misalign) begin
      state_nx = MON_OPEN;
    end else if (st_drop) begin
      state_nx = MON_OPEN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= MON_OPEN;
    end else begin
      state <= state_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q <= '0;
    end else if (tag_en) begin
      tag_q <= word_addr;
    end
  end

endmodule

// File: rtl/excl_resp.sv
module excl_resp
  import excl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  dec_t dec,
  input  logic stx_ok,
  output logic stat_valid,
  output logic stat_fail,
  output logic align_err
);

  logic fail_en;

  assign fail_en = dec.stx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_valid <= 1'b0;
      align_err  <= 1'b0;
    end else begin
      stat_valid <= dec.stx;
      align_err  <= (dec.ldx || dec.stx) && dec.misalign;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_fail <= 1'b0;
    end else if (fail_en) begin
      stat_fail <= !stx_ok;
    end
  end

endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
  import excl_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int WORD_BYTES   = 4,
  parameter int STORE_POLICY = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              mon_clear,
  output logic              mem_we,
  output logic              stat_valid,
  output logic              stat_fail,
  output logic              align_err
);

  dec_t dec;
  mon_e state;
  logic tag_hit;
  logic stx_ok;

  excl_decode #(
    .ADDR_W    (ADDR_W),
    .WORD_BYTES(WORD_BYTES)
  ) u_decode (
    .req_valid(req_valid),
    .req_op   (req_op),
    .req_addr (req_addr),
    .dec      (dec)
  );

  excl_resv #(
    .ADDR_W      (ADDR_W),
    .WORD_BYTES  (WORD_BYTES),
    .STORE_POLICY(STORE_POLICY)
  ) u_resv (
    .clk      (clk),
    .rst_n    (rst_n),
    .dec      (dec),
    .req_addr (req_addr),
    .mon_clear(mon_clear),
    .state    (state),
    .tag_hit  (tag_hit)
  );

  assign stx_ok = dec.stx && !dec.misalign && !mon_clear
                  && (state == MON_EXCL) && tag_hit;
  assign mem_we = dec.st || stx_ok;

  excl_resp u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .dec       (dec),
    .stx_ok    (stx_ok),
    .stat_valid(stat_valid),
    .stat_fail (stat_fail),
    .align_err (align_err)
  );

endmodule

// File: rtl/excl_monitor_chk.sv
module excl_monitor_chk
  import excl_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [1:0] req_op,
  input logic       mon_clear,
  input logic       misalign,
  input logic       mem_we,
  input logic       stat_valid,
  input logic       stat_fail,
  input mon_e       state
);

  logic is_stx;
  logic is_ldx;

  assign is_stx = req_valid && (req_op == OP_STX);
  assign is_ldx = req_valid && (req_op == OP_LDX);

  AST_STATUS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    is_stx |=> stat_valid); // R10

  AST_STATUS_ONLY_STX: assert property (@(posedge clk) disable iff (!rst_n)
    !is_stx |=> !stat_valid); // R10

  AST_NO_WRITE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (is_stx && state == MON_OPEN) |-> !mem_we); // R3

  AST_FAIL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (is_stx && !mem_we) |=> (stat_valid && stat_fail)); // R5

  AST_CLEAR_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    mon_clear |=> (state == MON_OPEN)); // R7

  AST_LDX_RESERVES: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ldx && !misalign && !mon_clear) |=> (state == MON_EXCL)); // R2

  AST_MISALIGN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ((is_ldx || is_stx) && misalign && !mon_clear) |=> $stable(state)); // R9

  AST_MISALIGN_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ((is_ldx || is_stx) && misalign) |-> !mem_we); // R9

endmodule

bind excl_monitor excl_monitor_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_op    (req_op),
  .mon_clear (mon_clear),
  .misalign  (dec.misalign),
  .mem_we    (mem_we),
  .stat_valid(stat_valid),
  .stat_fail (stat_fail),
  .state     (state)
);

// File: tb/test_excl_monitor.sv
`timescale 1ns/1ps
module test_excl_monitor;

  localparam int ADDR_W = 8;
  localparam int NWORDS = 64;

  logic              clk;
  logic              rst_n;
  logic              req_valid;
  logic [1:0]        req_op;
  logic [ADDR_W-1:0] req_addr;
  logic              mon_clear;
  logic              mem_we;
  logic              stat_valid;
  logic              stat_fail;
  logic              align_err;

  int n_checks;
  int n_fails;
  bit done;

  logic s_we, s_sv, s_sf, s_err;

  excl_monitor i_excl_monitor (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_addr  (req_addr),
    .mon_clear (mon_clear),
    .mem_we    (mem_we),
    .stat_valid(stat_valid),
    .stat_fail (stat_fail),
    .align_err (align_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive one request at a falling edge, sample mem_we in the request cycle
  // and the registered responses at the following falling edge
  task automatic issue(input logic [1:0] op, input int addr, input logic clr);
    @(negedge clk);
    req_valid = 1'b1;
    req_op    = op;
    req_addr  = ADDR_W'(addr);
    mon_clear = clr;
    #2 s_we = mem_we;
    @(negedge clk);
    s_sv  = stat_valid;
    s_sf  = stat_fail;
    s_err = align_err;
    req_valid = 1'b0;
    mon_clear = 1'b0;
    req_op    = 2'd0;
  endtask

  task automatic stx_expect(input int addr, input logic clr, input bit ok, input string req);
    issue(2'd3, addr, clr);
    check(s_we == ok, req, s_we, ok);
    check(s_sv == 1'b1 && s_sf == !ok, req, s_sf, !ok);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    done = 1'b0;
    n_checks = 0;
    n_fails = 0;
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_op = 2'd0;
    req_addr = '0;
    mon_clear = 1'b0;
    repeat (3) @(negedge clk);
    check(stat_valid == 1'b0, "R1", stat_valid, 0);
    check(align_err == 1'b0, "R1", align_err, 0);
    rst_n = 1'b1;
    @(negedge clk);
    stx_expect(0, 1'b0, 1'b0, "R1");
    stx_expect(20, 1'b0, 1'b0, "R3");

    // R2 R4 R5: every reserved word against every store word
    for (int la = 0; la < NWORDS; la++) begin
      for (int sa = 0; sa < NWORDS; sa++) begin
        issue(2'd2, la * 4, 1'b0);
        check(s_sv == 1'b0 && s_err == 1'b0, "R10", s_sv, 0);
        stx_expect(sa * 4, 1'b0, la == sa, (la == sa) ? "R2" : "R5");
      end
    end

    // R4: success returns to Open
    issue(2'd2, 20, 1'b0);
    stx_expect(20, 1'b0, 1'b1, "R4");
    stx_expect(20, 1'b0, 1'b0, "R4");

    // R8: plain store between reservation and store-exclusive
    for (int p = 0; p < NWORDS; p++) begin
      issue(2'd2, 20, 1'b0);
      issue(2'd1, p * 4, 1'b0);
      check(s_we == 1'b1, "R8", s_we, 1);
      check(s_sv == 1'b0, "R10", s_sv, 0);
      stx_expect(20, 1'b0, p != 5, "R8");
    end

    // R6: newer reservation replaces older
    issue(2'd2, 20, 1'b0);
    issue(2'd2, 40, 1'b0);
    stx_expect(20, 1'b0, 1'b0, "R6");
    issue(2'd2, 20, 1'b0);
    issue(2'd2, 40, 1'b0);
    stx_expect(40, 1'b0, 1'b1, "R6");

    // R7: clear alone, with load-exclusive, with store-exclusive
    issue(2'd2, 20, 1'b0);
    issue(2'd0, 0, 1'b1);
    stx_expect(20, 1'b0, 1'b0, "R7");
    issue(2'd2, 20, 1'b1);
    stx_expect(20, 1'b0, 1'b0, "R7");
    issue(2'd2, 20, 1'b0);
    stx_expect(20, 1'b1, 1'b0, "R7");

    // R11: plain load keeps reservation
    issue(2'd2, 20, 1'b0);
    issue(2'd0, 20, 1'b0);
    check(s_we == 1'b0 && s_sv == 1'b0, "R11", s_we, 0);
    stx_expect(20, 1'b0, 1'b1, "R11");

    // R9: misaligned exclusives
    for (int off = 1; off < 4; off++) begin
      issue(2'd2, 20 + off, 1'b0);
      check(s_err == 1'b1 && s_we == 1'b0, "R9", s_err, 1);
      stx_expect(20, 1'b0, 1'b0, "R9");
      issue(2'd2, 20, 1'b0);
      issue(2'd2, 40 + off, 1'b0);
      check(s_err == 1'b1, "R9", s_err, 1);
      stx_expect(20, 1'b0, 1'b1, "R9");
      issue(2'd2, 20, 1'b0);
      stx_expect(20 + off, 1'b0, 1'b0, "R9");
      check(s_err == 1'b1, "R9", s_err, 1);
      stx_expect(20, 1'b0, 1'b1, "R9");
      check(s_err == 1'b0, "R9", s_err, 0);
    end

    // R10: strobe lasts one cycle
    issue(2'd2, 8, 1'b0);
    issue(2'd3, 8, 1'b0);
    @(negedge clk);
    check(stat_valid == 1'b0, "R10", stat_valid, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule